// File: doc/BRIEF.md
# Oscillation Stabilization Wait Timer

This block holds off the switch to a crystal clock until that clock has run for a programmed number of its own cycles. A start pulse, raised by the clock controller when the oscillator is enabled or when a low-power stop is released, begins the count. The counter runs on the oscillator clock itself, so any time before the crystal starts to swing is not part of the wait. When the selected length has elapsed, the block drops busy and raises done, which tells the clock controller that the switch-over may happen.

Software picks one of eight wait lengths through a 3-bit select register on the bus clock. It can follow the progress of the wait through an 8-bit read-only status word. That word is a thermometer code: each bit marks one wait threshold that has been passed. The status word never goes beyond the chosen length. It reaches the bus side through a two-flop synchroniser. Writes to the select register are refused while the synchronised busy flag is high. The length in use is latched at each start, so the running count never depends on the bus side. There are no data streams here, so every pin is a plain level or pulse.

A parameter shortens every wait by the same power of two, so that a bench can sweep all eight lengths. At its default of zero, the lengths are the full ones.

Top module: `owt_wait_timer`

## Requirements
- R1: After reset the select register reads 0x07, with bits 7..3 zero. The status word reads 0, and busy and done are both low.
- R2: Select codes 0 to 7 give waits of 2^(8-S), 2^(9-S), 2^(10-S), 2^(11-S), 2^(13-S), 2^(15-S), 2^(17-S) and 2^(18-S) oscillator cycles, where S is the shift parameter. Done rises on the oscillator edge that lies exactly that many cycles after the edge that sampled start.
- R3: Busy is high from the edge that samples start until the edge that raises done. Busy and done are never high together. Once done is high, the counter is stopped and done stays high until the next start.
- R4: Status bit k (0 to 7) goes high on the edge at which the elapsed count equals the wait length of code k, provided k is not above the latched select code. Once set, a bit stays high until the next start.
- R5: Status bits above the latched select code are never set. After a completed wait with code c, the status word settles at 2^(c+1)-1.
- R6: A start pulse clears done and the status word and restarts the count from zero. This also holds when a wait is already in progress.
- R7: A select write takes effect at the next bus edge when the synchronised busy flag is low. While that flag is high, the write is ignored and the select register keeps its value.
- R8: The status word on the bus side equals the oscillator-side status word as it was two bus edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock that is counted |
| bus_clk | input | 1 | CPU bus clock for the select and status registers |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| start_i | input | 1 | One-cycle start pulse, oscillator domain |
| sel_wr_i | input | 1 | Select register write strobe, bus domain |
| sel_wdata_i | input | 3 | Select code to write |
| sel_rdata_o | output | 8 | Select register read value, upper five bits zero |
| stat_rdata_o | output | 8 | Synchronised thermometer status word |
| busy_o | output | 1 | Wait in progress, oscillator domain |
| done_o | output | 1 | Wait completed, oscillator domain |

## Verification
Some rules are checked on every cycle. Busy and done never overlap, done holds high until a start, and a start always leads to busy. The oscillator-side status word must stay a thermometer code that never passes the latched select code, and the select register must hold still whenever the synchronised busy flag is high. Other points can only be shown by the bench scenarios. These are the exact cycle on which done rises for each of the eight codes, the final status value after each wait, a restart in the middle of a count, a write refused during a wait, and the two-edge lag of the bus-side status word.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int NUM_CODES    = 8;
  localparam int SEL_W        = 3;
  localparam int REG_W        = 8;
  localparam int STAT_W       = NUM_CODES;
  localparam int MAX_BASE_EXP = 18;
  localparam logic [SEL_W-1:0] SEL_RST = 3'b111;

  // Log2 of the full-length wait for each select code (uneven spacing on purpose)
  function automatic int base_exp(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 9;
      3'd2:    return 10;
      3'd3:    return 11;
      3'd4:    return 13;
      3'd5:    return 15;
      3'd6:    return 17;
      default: return 18;
    endcase
  endfunction
endpackage

// File: rtl/owt_sync2.sv
module owt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/owt_counter.sv
module owt_counter
  import owt_pkg::*;
#(
  parameter int WAIT_SHIFT = 0,
  parameter int CNT_W      = MAX_BASE_EXP - WAIT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SEL_W-1:0]  sel_lat_o,
  output logic [STAT_W-1:0] hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic [SEL_W-1:0] sel_lat_q;
  logic             term_hit;

  // One comparator per threshold; hit_o[k] marks the last cycle before threshold k
  for (genvar k = 0; k < NUM_CODES; k++) begin : g_thr
    localparam int EXP_K = base_exp(3'(k)) - WAIT_SHIFT;
    localparam logic [CNT_W-1:0] LAST_K = CNT_W'((64'd1 << EXP_K) - 64'd1);
    assign hit_o[k] = busy_q && (cnt_q == LAST_K);
  end

  assign term_hit = hit_o[sel_lat_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sel_lat_q <= SEL_RST;
    end else if (start_i) begin
      cnt_q     <= '0;
      busy_q    <= 1'b1;
      done_q    <= 1'b0;
      sel_lat_q <= sel_i;
    end else if (busy_q) begin
      if (term_hit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sel_lat_o = sel_lat_q;
endmodule

// File: rtl/owt_status.sv
module owt_status
  import owt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [STAT_W-1:0] hit_i,
  input  logic [SEL_W-1:0]  sel_lat_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  for (genvar k = 0; k < STAT_W; k++) begin : g_bit
    logic allow;
    assign allow = (3'(k) <= sel_lat_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q[k] <= 1'b0;
      else if (start_i) stat_q[k] <= 1'b0;
      else if (hit_i[k] && allow) stat_q[k] <= 1'b1;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/owt_bus_if.sv
module owt_bus_if
  import owt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  wdata_i,
  input  logic              busy_osc_i,
  input  logic [STAT_W-1:0] stat_osc_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [REG_W-1:0]  sel_rdata_o,
  output logic [STAT_W-1:0] stat_rdata_o,
  output logic              busy_sync_o
);
  logic [SEL_W-1:0] sel_q;
  logic             busy_s;

  owt_sync2 #(.W(1)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .d_i(busy_osc_i), .q_o(busy_s)
  );

  owt_sync2 #(.W(STAT_W)) u_stat_sync (
    .clk(clk), .rst_n(rst_n), .d_i(stat_osc_i), .q_o(stat_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sel_q <= SEL_RST;
    else if (wr_i && !busy_s)  sel_q <= wdata_i;
  end

  assign sel_o       = sel_q;
  assign sel_rdata_o = {{(REG_W-SEL_W){1'b0}}, sel_q};
  assign busy_sync_o = busy_s;
endmodule

// File: rtl/owt_wait_timer.sv
module owt_wait_timer
  import owt_pkg::*;
#(
  parameter int WAIT_SHIFT = 0
) (
  input  logic             osc_clk,
  input  logic             bus_clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  output logic [REG_W-1:0] sel_rdata_o,
  output logic [REG_W-1:0] stat_rdata_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CNT_W = MAX_BASE_EXP - WAIT_SHIFT;

  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  sel_lat;
  logic [STAT_W-1:0] hit;
  logic [STAT_W-1:0] stat_osc;
  logic              busy_bsync;

  owt_counter #(.WAIT_SHIFT(WAIT_SHIFT), .CNT_W(CNT_W)) u_cnt (
    .clk(osc_clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_q),
    .busy_o(busy_o), .done_o(done_o), .sel_lat_o(sel_lat), .hit_o(hit)
  );

  owt_status u_stat (
    .clk(osc_clk), .rst_n(rst_n), .start_i(start_i), .hit_i(hit),
    .sel_lat_i(sel_lat), .stat_o(stat_osc)
  );

  owt_bus_if u_bus (
    .clk(bus_clk), .rst_n(rst_n), .wr_i(sel_wr_i), .wdata_i(sel_wdata_i),
    .busy_osc_i(busy_o), .stat_osc_i(stat_osc), .sel_o(sel_q),
    .sel_rdata_o(sel_rdata_o), .stat_rdata_o(stat_rdata_o),
    .busy_sync_o(busy_bsync)
  );
endmodule

// File: rtl/owt_checker.sv
module owt_checker (
  input logic       osc_clk,
  input logic       bus_clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] sel_rdata_o,
  input logic [7:0] stat_osc,
  input logic [2:0] sel_lat,
  input logic       busy_bsync
);
  assert_upper_zero_R1: assert property (@(posedge bus_clk) disable iff (!rst_n)
    sel_rdata_o[7:3] == 5'd0);

  assert_busy_done_excl_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_done_sticky_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  assert_done_at_sel_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(done_o) |-> stat_osc[sel_lat]);

  assert_thermometer_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ((stat_osc + 8'd1) & stat_osc) == 8'd0);

  assert_stat_capped_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (stat_osc & ~((8'd2 << sel_lat) - 8'd1)) == 8'd0);

  assert_start_restarts_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
    start_i |=> (busy_o && !done_o && stat_osc == 8'd0));

  assert_sel_frozen_R7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    busy_bsync |=> $stable(sel_rdata_o));
endmodule

bind owt_wait_timer owt_checker u_chk (
  .osc_clk(osc_clk), .bus_clk(bus_clk), .rst_n(rst_n), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .sel_rdata_o(sel_rdata_o),
  .stat_osc(stat_osc), .sel_lat(sel_lat), .busy_bsync(busy_bsync)
);

// File: tb/owt_wait_timer_tb.sv
`timescale 1ns/1ps
module owt_wait_timer_tb;
  localparam int SHIFT = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       wr;
  logic [2:0] wdata;
  logic [7:0] sel_rd, stat_rd;
  logic       busy, done;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  owt_wait_timer #(.WAIT_SHIFT(SHIFT)) u_dut (
    .osc_clk(clk), .bus_clk(clk), .rst_n(rst_n), .start_i(start),
    .sel_wr_i(wr), .sel_wdata_i(wdata), .sel_rdata_o(sel_rd),
    .stat_rdata_o(stat_rd), .busy_o(busy), .done_o(done)
  );

  function automatic int wait_len(input int code);
    int e [8] = '{8, 9, 10, 11, 13, 15, 17, 18};
    return 1 << (e[code] - SHIFT);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_sel, m_lat, m_elapsed, m_stat, m_busy, m_done;
  int m_bs1, m_bs2, m_ss1, m_ss2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 7; m_lat = 7; m_elapsed = 0; m_stat = 0; m_busy = 0; m_done = 0;
      m_bs1 = 0; m_bs2 = 0; m_ss1 = 0; m_ss2 = 0;
    end else begin
      int o_sel, o_bs2;
      o_sel = m_sel;
      o_bs2 = m_bs2;
      m_bs2 = m_bs1; m_bs1 = m_busy;
      m_ss2 = m_ss1; m_ss1 = m_stat;
      if (wr && o_bs2 == 0) m_sel = int'(wdata);
      if (start) begin
        m_busy = 1; m_done = 0; m_elapsed = 0; m_stat = 0; m_lat = o_sel;
      end else if (m_busy == 1) begin
        m_elapsed++;
        for (int k = 0; k <= m_lat; k++)
          if (m_elapsed == wait_len(k)) m_stat |= (1 << k);
        if (m_elapsed == wait_len(m_lat)) begin
          m_busy = 0; m_done = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 busy vs model", int'(busy), m_busy);
      chk("R2 done vs model", int'(done), m_done);
      chk("R7 select vs model", int'(sel_rd), m_sel);
      chk("R8 status vs model", int'(stat_rd), m_ss2);
    end
  end

  task automatic write_sel(input int code);
    wr = 1'b1; wdata = 3'(code);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int len, input string tag);
    int c = 0;
    while (!done && c < len + 20) begin
      @(negedge clk);
      c++;
    end
    chk(tag, c, len);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 select reset", int'(sel_rd), 7);
    chk("R1 status reset", int'(stat_rd), 0);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 done reset", int'(done), 0);

    // Every select code: exact done cycle and capped status
    for (int code = 0; code < 8; code++) begin
      write_sel(code);
      repeat (3) @(negedge clk);
      chk("R7 idle write", int'(sel_rd), code);
      pulse_start();
      chk("R3 busy after start", int'(busy), 1);
      wait_done(wait_len(code), "R2 done cycle");
      repeat (40) @(negedge clk);
      chk("R4 R5 final status", int'(stat_rd), (2 << code) - 1);
      chk("R3 done held", int'(done), 1);
    end

    // Write refused while busy
    write_sel(2);
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    write_sel(5);
    @(negedge clk);
    chk("R7 write while busy", int'(sel_rd), 2);
    wait_done(wait_len(2) - 12, "R7 wait unaffected");
    repeat (4) @(negedge clk);
    chk("R5 status code 2", int'(stat_rd), 7);

    // Restart in the middle of a wait
    write_sel(3);
    repeat (3) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R4 partial status", int'(stat_rd), 7);
    pulse_start();
    chk("R6 busy after restart", int'(busy), 1);
    repeat (3) @(negedge clk);
    chk("R6 status cleared", int'(stat_rd), 0);
    wait_done(wait_len(3) - 3, "R6 restart length");
    repeat (4) @(negedge clk);
    chk("R5 status code 3", int'(stat_rd), 15);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule